// File: doc/BRIEF.md
# Power-up reset delay sequencer

This block keeps a processor core in reset after power is applied and lets it go only after two delays in a row. The first delay is a fixed count of cycles of a free-running internal RC clock. It is measured from the end of the power-on pulse, and a configuration input can skip it. The second delay counts cycles of the main oscillator input. It lets a crystal or resonator settle, and it runs only when the clock-mode selection names one of the three crystal modes. The second delay also runs again on its own when the core wakes from sleep.

The voltage detector and the oscillators are outside the block. They appear as digital inputs: an active-high power-on pulse `por_i`, the RC clock `rc_clk` and the oscillator clock `osc_clk`. The controlling state machine runs on `osc_clk`. The RC-domain completion flag reaches it through a two-flop synchronizer. The master clear `mclr_n` and the wake pulse `wake_i` are taken to be synchronous to `osc_clk`. The configuration inputs are taken to be static while `por_i` is low.

The state machine has four states, given on `stage_o`:

- ST_IDLE (0): the timers are done and master clear holds the core.
- ST_PWRT (1): waiting for the RC delay.
- ST_OST (2): counting oscillator cycles.
- ST_RUN (3): the core is released.

Its transitions are:

- por_i → ST_PWRT (asynchronous).
- ST_PWRT → ST_OST on RC done in a crystal mode.
- ST_PWRT → ST_RUN or ST_IDLE on RC done in RC mode, chosen by `mclr_n`.
- ST_OST → ST_RUN or ST_IDLE on the last count, chosen by `mclr_n`.
- ST_RUN → ST_IDLE when `mclr_n` is low.
- ST_RUN → ST_OST on `wake_i` in a crystal mode.
- ST_IDLE → ST_RUN when `mclr_n` is high.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1 and `stage_o` is ST_PWRT. `core_rst_o` stays 1 for every cycle spent in ST_PWRT.
- R2: With `pwrt_en_i`=1, ST_PWRT is left only after `PWRT_CYCLES` rising edges of `rc_clk` following the fall of `por_i`. Up to one RC period plus three `osc_clk` cycles of synchronizer and state latency may be added.
- R3: With `pwrt_en_i`=0, the RC count is skipped. ST_PWRT lasts at most one RC period plus three `osc_clk` cycles.
- R4: In crystal modes (`clk_mode_i` 00=LP, 01=XT, 10=HS), ST_OST follows ST_PWRT and lasts exactly `OST_CYCLES` `osc_clk` cycles. `core_rst_o` stays 1 throughout ST_OST.
- R5: In mode 11 (RC oscillator), ST_OST is never entered. The core is released straight from ST_PWRT.
- R6: A one-cycle `wake_i` pulse in ST_RUN under a crystal mode starts ST_OST for exactly `OST_CYCLES` cycles and never ST_PWRT. In mode 11 the pulse has no effect.
- R7: `mclr_n` low forces `core_rst_o` to 1 on the next `osc_clk` edge from any stage. After the timers end, the stage is ST_IDLE.
- R8: Releasing `mclr_n` in ST_IDLE clears `core_rst_o` on the next edge, with no further delay.
- R9: `wake_i` in ST_IDLE is ignored: the stage stays ST_IDLE and the reset stays asserted.
- R10: `stage_o` encodes ST_IDLE=0, ST_PWRT=1, ST_OST=2, ST_RUN=3. `core_rst_o` is 0 only in ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | main oscillator clock, state machine domain |
| rc_clk | input | 1 | internal RC clock for the power-up delay |
| por_i | input | 1 | power-on pulse, active high, asynchronous |
| mclr_n | input | 1 | master clear, active low |
| wake_i | input | 1 | wake-from-sleep pulse |
| clk_mode_i | input | 2 | clock mode: 00 LP, 01 XT, 10 HS, 11 RC |
| pwrt_en_i | input | 1 | 1 enables the RC power-up delay |
| core_rst_o | output | 1 | registered core reset, active high |
| stage_o | output | 2 | current sequencer stage |

## Verification
On every `osc_clk` cycle, the assertions check several properties:

- the reset is held in ST_PWRT;
- ST_OST is never entered in RC mode;
- each ST_OST visit lasts exactly the oscillator count;
- ST_RUN never falls back to ST_PWRT without a power-on pulse;
- master clear forces reset on the next edge;
- releasing master clear from ST_IDLE frees the core on the next edge.

The RC delay length and its bypass cross a clock boundary, so only the bench's scenarios can show them. The bench measures them against a tolerance window for every mode and enable combination. The ignored wake in ST_IDLE and the wake re-entry per mode are also shown only by the bench.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PWRT = 2'd1,
        ST_OST  = 2'd2,
        ST_RUN  = 2'd3
    } stage_t;

    typedef enum logic [1:0] {
        MODE_LP = 2'd0,
        MODE_XT = 2'd1,
        MODE_HS = 2'd2,
        MODE_RC = 2'd3
    } clk_mode_t;

    function automatic logic is_crystal(input logic [1:0] mode);
        return mode != MODE_RC;
    endfunction

endpackage

// File: rtl/pwrup_rc_timer.sv
module pwrup_rc_timer #(
    parameter int CYCLES = 2592
) (
    input  logic rc_clk,
    input  logic por_i,
    input  logic en_i,
    output logic done_o
);
    localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt_q;
    logic         done_q;

    // Sticky completion flag; only a new power-on pulse clears it.
    always_ff @(posedge rc_clk or posedge por_i) begin
        if (por_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (!en_i || cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done_o = done_q;
endmodule

// File: rtl/pwrup_sync2.sv
module pwrup_sync2 #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [DEPTH-1:0] sh_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[DEPTH-2:0], d_i};
        end
    end

    assign q_o = sh_q[DEPTH-1];
endmodule

// File: rtl/pwrup_ost_timer.sv
module pwrup_ost_timer #(
    parameter int CYCLES = 1024
) (
    input  logic osc_clk,
    input  logic por_i,
    input  logic en_i,
    output logic done_o
);
    localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt_q;

    // Counts while the sequencer sits in the oscillator stage, clears otherwise.
    always_ff @(posedge osc_clk or posedge por_i) begin
        if (por_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int PWRT_CYCLES = 2592,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_DEPTH  = 2
) (
    input  logic       osc_clk,
    input  logic       rc_clk,
    input  logic       por_i,
    input  logic       mclr_n,
    input  logic       wake_i,
    input  logic [1:0] clk_mode_i,
    input  logic       pwrt_en_i,
    output logic       core_rst_o,
    output logic [1:0] stage_o
);
    stage_t state_q, state_d;
    logic   rst_q;
    logic   rc_done;
    logic   rc_done_sync;
    logic   ost_done;
    logic   crystal;

    assign crystal = is_crystal(clk_mode_i);

    pwrup_rc_timer #(.CYCLES(PWRT_CYCLES)) u_rc_timer (
        .rc_clk (rc_clk),
        .por_i  (por_i),
        .en_i   (pwrt_en_i),
        .done_o (rc_done)
    );

    pwrup_sync2 #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk (osc_clk),
        .rst (por_i),
        .d_i (rc_done),
        .q_o (rc_done_sync)
    );

    pwrup_ost_timer #(.CYCLES(OST_CYCLES)) u_ost_timer (
        .osc_clk (osc_clk),
        .por_i   (por_i),
        .en_i    (state_q == ST_OST),
        .done_o  (ost_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRT: begin
                if (rc_done_sync) begin
                    if (crystal)     state_d = ST_OST;
                    else if (mclr_n) state_d = ST_RUN;
                    else             state_d = ST_IDLE;
                end
            end
            ST_OST: begin
                if (ost_done) state_d = mclr_n ? ST_RUN : ST_IDLE;
            end
            ST_RUN: begin
                if (!mclr_n)                state_d = ST_IDLE;
                else if (wake_i && crystal) state_d = ST_OST;
            end
            ST_IDLE: begin
                if (mclr_n) state_d = ST_RUN;
            end
            default: state_d = ST_PWRT;
        endcase
    end

    // State register
    always_ff @(posedge osc_clk or posedge por_i) begin
        if (por_i) state_q <= ST_PWRT;
        else       state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge osc_clk or posedge por_i) begin
        if (por_i) rst_q <= 1'b1;
        else       rst_q <= (state_d != ST_RUN);
    end

    assign core_rst_o = rst_q;
    assign stage_o    = state_q;
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
    parameter int OST_CYCLES = 1024
) (
    input logic       osc_clk,
    input logic       por_i,
    input logic       mclr_n,
    input logic [1:0] clk_mode_i,
    input logic       core_rst_o,
    input logic [1:0] stage_o
);
    localparam int W = $clog2(OST_CYCLES + 1);
    logic [W-1:0] ost_len_q;

    always_ff @(posedge osc_clk or posedge por_i) begin
        if (por_i)               ost_len_q <= '0;
        else if (stage_o == 2'd2) ost_len_q <= ost_len_q + 1'b1;
        else                     ost_len_q <= '0;
    end

    a_r1_held_in_pwrt: assert property (@(posedge osc_clk) disable iff (por_i)
        stage_o == 2'd1 |-> core_rst_o);

    a_r5_no_ost_in_rc_mode: assert property (@(posedge osc_clk) disable iff (por_i)
        stage_o == 2'd2 |-> clk_mode_i != 2'd3);

    a_r4_ost_bounded: assert property (@(posedge osc_clk) disable iff (por_i)
        stage_o == 2'd2 |-> ost_len_q < W'(OST_CYCLES));

    a_r4_ost_full_length: assert property (@(posedge osc_clk) disable iff (por_i)
        ($past(stage_o) == 2'd2 && stage_o != 2'd2) |-> $past(ost_len_q) == W'(OST_CYCLES - 1));

    a_r6_no_pwrt_after_run: assert property (@(posedge osc_clk) disable iff (por_i)
        stage_o == 2'd3 |=> stage_o != 2'd1);

    a_r7_mclr_forces_reset: assert property (@(posedge osc_clk) disable iff (por_i)
        !mclr_n |=> core_rst_o);

    a_r8_release_at_once: assert property (@(posedge osc_clk) disable iff (por_i)
        (stage_o == 2'd0 && mclr_n) |=> !core_rst_o);
endmodule

bind pwrup_seq pwrup_seq_chk #(.OST_CYCLES(OST_CYCLES)) u_chk (
    .osc_clk    (osc_clk),
    .por_i      (por_i),
    .mclr_n     (mclr_n),
    .clk_mode_i (clk_mode_i),
    .core_rst_o (core_rst_o),
    .stage_o    (stage_o)
);

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;
    localparam int PW = 8;
    localparam int OC = 16;

    logic       osc_clk = 0, rc_clk = 0;
    logic       por_i = 1, mclr_n = 1, wake_i = 0, pwrt_en_i = 1;
    logic [1:0] clk_mode_i = 2'd1;
    logic       core_rst_o;
    logic [1:0] stage_o;

    int n_chk = 0, n_bad = 0;
    int pw_cnt, os_cnt;
    bit held_ok;

    always #10 osc_clk = ~osc_clk;  // 50 MHz
    always #30 rc_clk  = ~rc_clk;

    pwrup_seq #(.PWRT_CYCLES(PW), .OST_CYCLES(OC)) u_dut (
        .osc_clk(osc_clk), .rc_clk(rc_clk), .por_i(por_i), .mclr_n(mclr_n),
        .wake_i(wake_i), .clk_mode_i(clk_mode_i), .pwrt_en_i(pwrt_en_i),
        .core_rst_o(core_rst_o), .stage_o(stage_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watch a start-up or wake sequence until the core is released or held idle.
    task automatic measure();
        pw_cnt = 0; os_cnt = 0; held_ok = 1;
        for (int i = 0; i < 400; i++) begin
            @(negedge osc_clk);
            if (stage_o == 2'd3 || stage_o == 2'd0) break;
            if (stage_o == 2'd1) pw_cnt++;
            if (stage_o == 2'd2) os_cnt++;
            if (!core_rst_o) held_ok = 0;
        end
    endtask

    task automatic power_on(input logic [1:0] mode, input logic en);
        @(negedge osc_clk);
        por_i = 1; clk_mode_i = mode; pwrt_en_i = en;
        #5;
        check(core_rst_o == 1, "R1 reset during por", core_rst_o, 1);
        check(stage_o == 2'd1, "R10 stage during por", stage_o, 1);
        @(negedge osc_clk);
        por_i = 0;
        measure();
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        // Near-exhaustive sweep over mode x enable
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                power_on(2'(m), 1'(e));
                check(held_ok, "R1 R4 reset held before release", held_ok, 1);
                if (e == 1)
                    check(pw_cnt >= 3*PW - 2 && pw_cnt <= 3*PW + 7, "R2 rc delay", pw_cnt, 3*PW);
                else
                    check(pw_cnt <= 8, "R3 rc delay bypass", pw_cnt, 4);
                if (m != 3) check(os_cnt == OC, "R4 ost length", os_cnt, OC);
                else        check(os_cnt == 0,  "R5 ost skipped", os_cnt, 0);
                check(stage_o == 2'd3, "R10 run stage", stage_o, 3);
                check(core_rst_o == 0, "R10 reset released", core_rst_o, 0);

                // wake from sleep
                @(negedge osc_clk); wake_i = 1;
                @(negedge osc_clk); wake_i = 0;
                if (m != 3) begin
                    check(stage_o == 2'd2 && core_rst_o, "R6 wake enters ost", stage_o, 2);
                    os_cnt = 1; pw_cnt = 0;
                    for (int i = 0; i < 100 && stage_o != 2'd3; i++) begin
                        @(negedge osc_clk);
                        if (stage_o == 2'd2) os_cnt++;
                        if (stage_o == 2'd1) pw_cnt++;
                    end
                    check(os_cnt == OC, "R6 wake ost length", os_cnt, OC);
                    check(pw_cnt == 0, "R6 no pwrt on wake", pw_cnt, 0);
                end else begin
                    check(stage_o == 2'd3 && !core_rst_o, "R6 wake ignored rc mode", stage_o, 3);
                end
            end
        end

        // Master clear in RUN
        @(negedge osc_clk); mclr_n = 0;
        @(negedge osc_clk);
        check(core_rst_o == 1, "R7 mclr forces reset", core_rst_o, 1);
        check(stage_o == 2'd0, "R7 idle stage", stage_o, 0);
        wake_i = 1;
        @(negedge osc_clk); wake_i = 0;
        check(stage_o == 2'd0 && core_rst_o, "R9 wake in idle ignored", stage_o, 0);
        @(negedge osc_clk);
        check(stage_o == 2'd0 && core_rst_o, "R9 still idle", stage_o, 0);
        mclr_n = 1;
        @(negedge osc_clk);
        check(core_rst_o == 0 && stage_o == 2'd3, "R8 immediate release", core_rst_o, 0);

        // Master clear held through start-up (XT mode)
        mclr_n = 0;
        power_on(2'd1, 1'b1);
        check(os_cnt == OC, "R4 ost under mclr", os_cnt, OC);
        check(stage_o == 2'd0 && core_rst_o, "R7 idle after timers", stage_o, 0);
        @(negedge osc_clk); mclr_n = 1;
        @(negedge osc_clk);
        check(core_rst_o == 0, "R8 release after timers", core_rst_o, 0);

        // Master clear low during ost then released mid-count
        @(negedge osc_clk); wake_i = 1;
        @(negedge osc_clk); wake_i = 0; mclr_n = 0;
        @(negedge osc_clk);
        check(stage_o == 2'd2 && core_rst_o, "R7 mclr during ost keeps counting", stage_o, 2);
        mclr_n = 1;
        measure();
        check(stage_o == 2'd3 && !core_rst_o, "R4 run after ost", stage_o, 3);

        finish_run();
    end
endmodule